// File: doc/BRIEF.md
# Page-Boundary Program Splitter

This block sits in front of a serial flash program sequencer. It takes one byte-granular write request, given as a start byte address and a length in bytes, and turns it into a series of program commands. None of these commands crosses a flash page boundary. A request that fits inside one page becomes one command. A longer request becomes a leading partial page, then any number of whole pages, then a trailing partial page when bytes are left over.

Each command is a header carrying the chunk's start address and byte count, sent on a valid/ready channel. After each header the block opens a byte stream gate for exactly that many payload bytes, passes them from the input stream to the sequencer unchanged and in order, and closes the gate again before the next header is offered. The page size is two to the power of a shift value. That value is sampled when the request is accepted, so a request can target 256-byte pages (shift 8) or any other power-of-two page.

Top module: `pgm_page_splitter`

## Requirements
- R1: After a synchronous active-low reset, req_ready is 1 and cmd_valid, dout_valid, din_ready and done are all 0.
- R2: When the first byte (req_addr) and the last byte (req_addr + req_len - 1) fall in the same page, exactly one command is issued, with cmd_addr = req_addr and cmd_len = req_len. This includes a request that ends exactly on a page boundary.
- R3: When a request spans pages, the first command has cmd_addr = req_addr and cmd_len = page size - (req_addr mod page size).
- R4: Between the first and the last command, every command starts on a page boundary and has cmd_len equal to one full page. A header that is held off by cmd_ready low keeps its address and length.
- R5: When bytes remain after the whole pages, they are issued as a final command that starts on a page boundary and is shorter than one page.
- R6: Every command has cmd_len > 0 and satisfies (cmd_addr mod page size) + cmd_len <= page size.
- R7: The command addresses are contiguous, and the command lengths add up to req_len.
- R8: After each accepted header, exactly cmd_len bytes pass from din to dout. No byte passes while a header is pending, so din_ready is 0 whenever cmd_valid is 1.
- R9: A request with req_len = 0 produces no command, and done is 1 in the cycle after the request is accepted.
- R10: The page size is 2^page_shift, with page_shift sampled on request acceptance. Changing page_shift during a request has no effect on that request's commands.
- R11: done is a single-cycle pulse in the cycle after the final payload byte is transferred. req_ready is 1 only while the block is idle, and no command or data moves while it is idle.
- R12: Payload bytes leave on dout_data with the same values and in the same order as they arrive on din_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Program request offered |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | ADDR_W | Start byte address of the request |
| req_len | input | LEN_W | Request length in bytes |
| page_shift | input | SHIFT_W | log2 of the page size, sampled on acceptance |
| cmd_valid | output | 1 | Chunk header valid |
| cmd_ready | input | 1 | Sequencer takes the header |
| cmd_addr | output | ADDR_W | Chunk start byte address |
| cmd_len | output | LEN_W | Chunk length in bytes |
| din_valid | input | 1 | Input payload byte valid |
| din_ready | output | 1 | Input payload byte taken |
| din_data | input | 8 | Input payload byte |
| dout_valid | output | 1 | Payload byte to sequencer valid |
| dout_ready | input | 1 | Sequencer takes the payload byte |
| dout_data | output | 8 | Payload byte to sequencer |
| done | output | 1 | One-cycle pulse when the request is complete |

## Verification
The bound checker watches the properties that hold on every cycle:
- No emitted chunk crosses a page of the size sampled at acceptance.
- A stalled header stays stable.
- No payload byte goes beyond the current chunk's budget.
- The stream is closed while a header is pending or the block is idle.
- done lasts one cycle.
- A zero-length request finishes at once.

Only the bench scenarios can show that the chunk sequence is correct as a whole. This covers the exact leading, whole-page and trailing lengths, the addresses following on from each other, the lengths adding up to the request, the payload order, and the fact that a page_shift change after acceptance is ignored.

// File: rtl/pgs_pkg.sv
// Package: shared types of the page-boundary program splitter.
// Assumes: nothing beyond the standard language.
package pgs_pkg;

    // Control states of the splitter sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } pgs_state_e;

endpackage

// File: rtl/pgs_chunk_calc.sv
// Module: pgs_chunk_calc
// Computes the length of the next chunk. This is the smaller of the bytes
// still to be programmed and the room left between the current address and
// the end of its page.
// Assumes: shift < ADDR_W and LEN_W <= ADDR_W + 1. Purely combinational.
module pgs_chunk_calc #(
    parameter int ADDR_W  = 24,
    parameter int LEN_W   = 16,
    parameter int SHIFT_W = 5
) (
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [LEN_W-1:0]   remain,
    input  logic [SHIFT_W-1:0] shift,
    output logic [LEN_W-1:0]   chunk_len
);

    localparam int ROOM_W = ADDR_W + 1;
    localparam int CMP_W  = (ROOM_W > LEN_W) ? ROOM_W : LEN_W;

    logic [ROOM_W-1:0] page_bytes;
    logic [ROOM_W-1:0] in_page_off;
    logic [ROOM_W-1:0] room;
    logic [CMP_W-1:0]  room_cmp;
    logic [CMP_W-1:0]  rem_cmp;

    // Room to the page end, then the minimum of room and remaining bytes.
    always_comb begin
        page_bytes  = ROOM_W'(1) << shift;
        in_page_off = {1'b0, cur_addr} & (page_bytes - ROOM_W'(1));
        room        = page_bytes - in_page_off;
        room_cmp    = CMP_W'(room);
        rem_cmp     = CMP_W'(remain);
        chunk_len   = (rem_cmp <= room_cmp) ? remain : LEN_W'(room);
    end

endmodule

// File: rtl/pgs_byte_gate.sv
// Module: pgs_byte_gate
// Lets a loaded number of payload bytes through from the input stream to the
// output stream, then closes. It flags the transfer of the final byte.
// Assumes: load only happens while the budget is zero. Data passes through
// combinationally with no buffering.
module pgs_byte_gate #(
    parameter int LEN_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              din_valid,
    output logic              din_ready,
    input  logic [DATA_W-1:0] din_data,
    output logic              dout_valid,
    input  logic              dout_ready,
    output logic [DATA_W-1:0] dout_data,
    output logic              last_fire
);

    logic [LEN_W-1:0] budget;
    logic             open_gate;
    logic             xfer;

    // Gate is open while bytes of the current chunk are outstanding.
    always_comb begin
        open_gate  = (budget != '0);
        dout_valid = din_valid & open_gate;
        din_ready  = dout_ready & open_gate;
        dout_data  = din_data;
        xfer       = din_valid & dout_ready & open_gate;
        last_fire  = xfer & (budget == LEN_W'(1));
    end

    // Byte budget: loaded per chunk and counted down per transferred byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            budget <= '0;
        end else if (load) begin
            budget <= load_len;
        end else if (xfer) begin
            budget <= budget - LEN_W'(1);
        end
    end

endmodule

// File: rtl/pgm_page_splitter.sv
// Module: pgm_page_splitter (top)
// Splits a byte-granular program request into page-contained chunks. Each
// chunk is announced by a header (address, length) and followed by exactly
// that many payload bytes gated from the input stream.
// Assumes: page_shift < ADDR_W and 2^page_shift fits in LEN_W + 1 bits.
// The downstream sequencer handles the serial framing and the busy wait.
module pgm_page_splitter #(
    parameter int ADDR_W  = 24,
    parameter int LEN_W   = 16,
    parameter int SHIFT_W = 5,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [SHIFT_W-1:0] page_shift,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [LEN_W-1:0]   cmd_len,
    input  logic               din_valid,
    output logic               din_ready,
    input  logic [DATA_W-1:0]  din_data,
    output logic               dout_valid,
    input  logic               dout_ready,
    output logic [DATA_W-1:0]  dout_data,
    output logic               done
);

    import pgs_pkg::*;

    pgs_state_e         state;
    logic [ADDR_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   remain;
    logic [SHIFT_W-1:0] shift_q;
    logic [LEN_W-1:0]   chunk_q;
    logic [LEN_W-1:0]   next_chunk;
    logic               hdr_fire;
    logic               last_byte;

    pgs_chunk_calc #(
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W),
        .SHIFT_W (SHIFT_W)
    ) u_calc (
        .cur_addr  (cur_addr),
        .remain    (remain),
        .shift     (shift_q),
        .chunk_len (next_chunk)
    );

    pgs_byte_gate #(
        .LEN_W  (LEN_W),
        .DATA_W (DATA_W)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (hdr_fire),
        .load_len   (next_chunk),
        .din_valid  (din_valid),
        .din_ready  (din_ready),
        .din_data   (din_data),
        .dout_valid (dout_valid),
        .dout_ready (dout_ready),
        .dout_data  (dout_data),
        .last_fire  (last_byte)
    );

    // Port decode of the control state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        cmd_valid = (state == ST_HDR);
        cmd_addr  = cur_addr;
        cmd_len   = next_chunk;
        done      = (state == ST_DONE);
        hdr_fire  = (state == ST_HDR) & cmd_ready;
    end

    // Request sequencer: accept, announce chunk, stream chunk, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            shift_q  <= '0;
            chunk_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_addr <= req_addr;
                        remain   <= req_len;
                        shift_q  <= page_shift;
                        state    <= (req_len == '0) ? ST_DONE : ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (cmd_ready) begin
                        chunk_q <= next_chunk;
                        state   <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (last_byte) begin
                        cur_addr <= cur_addr + ADDR_W'(chunk_q);
                        remain   <= remain - chunk_q;
                        state    <= (remain == chunk_q) ? ST_DONE : ST_HDR;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/pgs_checker.sv
// Module: pgs_checker
// Watches the splitter's ports with its own record of the accepted page
// size and of the open byte budget, and flags protocol breaches.
// Assumes: bound to pgm_page_splitter. Observation only.
module pgs_checker #(
    parameter int ADDR_W  = 24,
    parameter int LEN_W   = 16,
    parameter int SHIFT_W = 5,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [LEN_W-1:0]   req_len,
    input logic [SHIFT_W-1:0] page_shift,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic [ADDR_W-1:0]  cmd_addr,
    input logic [LEN_W-1:0]   cmd_len,
    input logic               din_ready,
    input logic               dout_valid,
    input logic               dout_ready,
    input logic               done
);

    localparam int ROOM_W = ADDR_W + 1;

    logic [SHIFT_W-1:0] shift_ck;
    logic [LEN_W-1:0]   budget_ck;
    logic [ROOM_W-1:0]  psize_ck;

    // Own copy of the page shift taken at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_ck <= '0;
        end else if (req_valid && req_ready) begin
            shift_ck <= page_shift;
        end
    end

    // Own count of payload bytes still owed to the current chunk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            budget_ck <= '0;
        end else if (cmd_valid && cmd_ready) begin
            budget_ck <= cmd_len;
        end else if (dout_valid && dout_ready) begin
            budget_ck <= budget_ck - LEN_W'(1);
        end
    end

    // Page size seen by the checker.
    always_comb psize_ck = ROOM_W'(1) << shift_ck;

    // R6
    chunk_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_len != '0) &&
            ((({1'b0, cmd_addr} & (psize_ck - ROOM_W'(1))) + ROOM_W'(cmd_len)) <= psize_ck));

    // R4
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len));

    // R8
    byte_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid && dout_ready |-> budget_ck != '0);

    // R8
    hdr_after_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (budget_ck == '0) && !din_ready && !dout_valid);

    // R9
    zero_len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_len == '0) |=> done);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid && !dout_valid && !din_ready);

endmodule

bind pgm_page_splitter pgs_checker #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .SHIFT_W (SHIFT_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_len    (req_len),
    .page_shift (page_shift),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_addr   (cmd_addr),
    .cmd_len    (cmd_len),
    .din_ready  (din_ready),
    .dout_valid (dout_valid),
    .dout_ready (dout_ready),
    .done       (done)
);

// File: tb/sim_pgm_page_splitter.sv
// Bench for pgm_page_splitter: directed corner requests plus seeded random
// requests, with random handshake pressure, checked against a bench model.
module sim_pgm_page_splitter;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 24;
    localparam int LEN_W      = 16;
    localparam int SHIFT_W    = 5;
    localparam int DATA_W     = 8;
    localparam int WATCHDOG   = 180000;
    localparam int MAX_CHUNKS = 512;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [LEN_W-1:0]   req_len = '0;
    logic [SHIFT_W-1:0] page_shift = '0;
    logic               cmd_valid;
    logic               cmd_ready = 1'b0;
    logic [ADDR_W-1:0]  cmd_addr;
    logic [LEN_W-1:0]   cmd_len;
    logic               din_valid = 1'b0;
    logic               din_ready;
    logic [DATA_W-1:0]  din_data = '0;
    logic               dout_valid;
    logic               dout_ready = 1'b0;
    logic [DATA_W-1:0]  dout_data;
    logic               done;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    longint exp_addr [MAX_CHUNKS];
    longint exp_len  [MAX_CHUNKS];
    int     exp_n;

    pgm_page_splitter #(
        .ADDR_W (ADDR_W), .LEN_W (LEN_W), .SHIFT_W (SHIFT_W), .DATA_W (DATA_W)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_len (req_len), .page_shift (page_shift),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
        .cmd_addr (cmd_addr), .cmd_len (cmd_len),
        .din_valid (din_valid), .din_ready (din_ready), .din_data (din_data),
        .dout_valid (dout_valid), .dout_ready (dout_ready), .dout_data (dout_data),
        .done (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: an overrun counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < %0d", cycles, WATCHDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fails = n_fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Bench model of the chunk sequence for one request.
    function automatic void build_expect(input longint a, input longint len, input int sh);
        longint psz;
        longint ad;
        longint rem;
        longint room;
        longint c;
        psz   = longint'(1) << sh;
        ad    = a;
        rem   = len;
        exp_n = 0;
        while (rem > 0 && exp_n < MAX_CHUNKS) begin
            room = psz - (ad % psz);
            c    = (rem < room) ? rem : room;
            exp_addr[exp_n] = ad;
            exp_len[exp_n]  = c;
            exp_n = exp_n + 1;
            ad  = ad + c;
            rem = rem - c;
        end
    endfunction

    function automatic string chunk_tag(input int idx, input int n, input longint len, input int sh);
        if (n == 1)                           return "R2";
        if (idx == 0)                         return "R3";
        if (idx == n - 1 && len < (longint'(1) << sh)) return "R5";
        return "R4";
    endfunction

    // One request with random handshake pressure; page_shift is scrambled
    // after acceptance to show it is held (R10).
    task automatic run_req(input longint a, input longint len, input int sh, input string rtag);
        int      ncmd;
        longint  nout;
        longint  din_idx;
        longint  in_chunk;
        longint  cur_len;
        int      cyc;
        bit      seen_done;
        longint  psz;
        psz = longint'(1) << sh;
        build_expect(a, len, sh);
        @(negedge clk);
        req_valid  = 1'b1;
        req_addr   = ADDR_W'(a);
        req_len    = LEN_W'(len);
        page_shift = SHIFT_W'(sh);
        #1;
        chk(req_ready == 1'b1, "R11", "req_ready when idle", longint'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        ncmd = 0; nout = 0; din_idx = 0; in_chunk = 0; cur_len = 0;
        cyc = 0; seen_done = 1'b0;
        while (!seen_done && cyc < 40000) begin
            page_shift = SHIFT_W'($urandom_range(3, 9));
            cmd_ready  = ($urandom_range(0, 3) != 0);
            din_valid  = ($urandom_range(0, 3) != 0);
            dout_ready = ($urandom_range(0, 3) != 0);
            din_data   = DATA_W'(din_idx * 7 + 3);
            #1;
            if (done) begin
                seen_done = 1'b1;
                if (len == 0)
                    chk(cyc == 0, "R9", "done cycles after accept", cyc, 0);
            end else begin
                if (cmd_valid && din_ready)
                    chk(1'b0, "R8", "din_ready during header", 1, 0);
                if (cmd_valid && cmd_ready) begin
                    if (ncmd > 0)
                        chk(in_chunk == cur_len, "R8", "bytes in chunk", in_chunk, cur_len);
                    if (ncmd < exp_n) begin
                        chk(longint'(cmd_addr) == exp_addr[ncmd],
                            {chunk_tag(ncmd, exp_n, exp_len[ncmd], sh), " ", rtag},
                            "cmd_addr", longint'(cmd_addr), exp_addr[ncmd]);
                        chk(longint'(cmd_len) == exp_len[ncmd],
                            {chunk_tag(ncmd, exp_n, exp_len[ncmd], sh), " ", rtag},
                            "cmd_len", longint'(cmd_len), exp_len[ncmd]);
                    end else begin
                        chk(1'b0, "R7", "extra command index", ncmd, exp_n);
                    end
                    chk((longint'(cmd_addr) % psz) + longint'(cmd_len) <= psz && cmd_len != 0,
                        "R6", "chunk end offset", (longint'(cmd_addr) % psz) + longint'(cmd_len), psz);
                    cur_len  = longint'(cmd_len);
                    in_chunk = 0;
                    ncmd     = ncmd + 1;
                end
                if (dout_valid && dout_ready) begin
                    chk(dout_data == DATA_W'(nout * 7 + 3), "R12", "payload byte",
                        longint'(dout_data), longint'(DATA_W'(nout * 7 + 3)));
                    nout     = nout + 1;
                    in_chunk = in_chunk + 1;
                end
                if (din_valid && din_ready)
                    din_idx = din_idx + 1;
                @(negedge clk);
                cyc = cyc + 1;
            end
        end
        chk(seen_done, "R11", "done seen", longint'(seen_done), 1);
        chk(ncmd == exp_n, "R7", "command count", ncmd, exp_n);
        chk(nout == len, "R7", "total payload bytes", nout, len);
        if (ncmd > 0)
            chk(in_chunk == cur_len, "R8", "bytes in last chunk", in_chunk, cur_len);
        cmd_ready = 1'b0; din_valid = 1'b0; dout_ready = 1'b0;
        @(negedge clk);
        #1;
        chk(done == 1'b0, "R11", "done is one cycle", longint'(done), 0);
        chk(req_ready == 1'b1, "R11", "idle after done", longint'(req_ready), 1);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready", longint'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid", longint'(cmd_valid), 0);
        chk(dout_valid == 1'b0, "R1", "dout_valid", longint'(dout_valid), 0);
        chk(din_ready == 1'b0, "R1", "din_ready", longint'(din_ready), 0);
        chk(done == 1'b0, "R1", "done", longint'(done), 0);

        // Directed corners
        run_req(24'h000010, 16,   8, "R2");   // inside one page
        run_req(24'h0000F0, 16,   8, "R2");   // ends exactly on boundary
        run_req(24'h0000F0, 17,   8, "R3");   // one byte over
        run_req(24'h000080, 600,  8, "R4");   // partial + whole + partial
        run_req(24'h000200, 512,  8, "R4");   // aligned whole pages
        run_req(24'h000300, 300,  8, "R5");   // whole page + tail
        run_req(24'h001234, 0,    8, "R9");   // zero length
        run_req(24'hFFFFF8, 8,    8, "R2");   // top of address space
        run_req(24'h000007, 40,   4, "R10");  // 16-byte pages
        run_req(24'h000005, 1,    4, "R10");  // single byte
        run_req(24'h000040, 2048, 11,"R10");  // 2 KiB pages

        // Seeded random requests
        for (int i = 0; i < 40; i++) begin
            longint a;
            longint l;
            int     s;
            a = longint'($urandom_range(0, 32'h00FF_FFFF)) & 64'h00FF_F000;
            a = a + longint'($urandom_range(0, 4095));
            l = ($urandom_range(0, 7) == 0) ? 0 : longint'($urandom_range(1, 700));
            if (a + l > 64'h0100_0000) a = 64'h0100_0000 - l;
            s = $urandom_range(4, 9);
            run_req(a, l, s, "R10");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule